// File: doc/BRIEF.md
# Masked Parallel I/O Port Controller

This block manages one parallel I/O port of `PORT_W` bits (32 by default) through a small register interface that finishes every access in one cycle. Each bit has its own direction, where a one makes the bit an output. It also has an output latch whose value drives the pin output. Software can change the latch in three ways. A set register raises the bits written as one. A clear register lowers the bits written as one. A whole-port value register writes every bit that a mask register does not shield.

The external pin values pass through a multi-stage synchroniser before they can be read. A read of the port value register returns the synchronised pins with the shielded bits forced to zero. The output latch, the direction register and the mask register can all be read back. Every write uses byte-lane strobes, so a byte-wide access changes only its own lane.

Top module: `fgpio_port`

## Requirements
- R1: Reset is synchronous and active high. After reset the direction, mask and output latch are all zero, so `pin_oe` = 0 and `pin_out` = 0, and `rdata_vld` is low.
- R2: A write to the direction register (offset 4) loads the bits of the enabled byte lanes, where one means output. `pin_oe` follows the register from the next cycle, and a read of offset 4 returns it.
- R3: A write to the set register (offset 2) sets the latch bits that are written as one in enabled lanes. All other latch bits keep their value.
- R4: A write to the clear register (offset 3) clears the latch bits that are written as one in enabled lanes. All other latch bits keep their value.
- R5: A write to the port value register (offset 0) copies `wdata` into the latch bits that lie in enabled lanes and whose mask bit (mask register, offset 5, one means shielded) is zero. Shielded bits keep their value.
- R6: A read of offset 0 returns the synchronised pin state AND NOT mask, so shielded bits read as zero.
- R7: Byte lane k of `be` covers bits 8k+7..8k. On every writable register, bits in disabled lanes are left unchanged.
- R8: A value on `pin_in` is first captured at a clock edge E. A read request sampled at edge E+2 or later returns it. A read sampled at E or E+1 still returns the earlier value.
- R9: A read request (`req`=1, `we`=0) sampled at an edge gives `rdata_vld`=1 with the data after that same edge. In every cycle without a read, `rdata_vld` is 0.
- R10: `pin_out` always equals the latch, whatever the direction. A read of offset 1 returns the latch. Reads of offsets 2, 3, 6 and 7 return zero.
- R11: Writes to offset 1 and to the unused offsets 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, valid for one cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register offset |
| be | input | PORT_W/8 | Byte-lane write enables |
| wdata | input | PORT_W | Write data |
| rdata | output | PORT_W | Read data, registered |
| rdata_vld | output | 1 | Read data valid |
| pin_in | input | PORT_W | Asynchronous pin inputs |
| pin_out | output | PORT_W | Output latch value |
| pin_oe | output | PORT_W | Per-bit output enable (direction) |

## Verification
The bench targets the places where two shields overlap. One case is a port value write under a partial mask with only some byte lanes enabled: a design that ignores either shield corrupts bits it should keep. Partial-lane set and clear writes would go wrong if the strobes were dropped, and lanes outside the access would change. Pins are changed right before a read, and the result is compared against a latency of exactly two edges: a synchroniser that is too short or too long returns the wrong pin word. Writes to the read-only and unused offsets are followed by readbacks, which would expose a decoder that aliases those offsets onto a live register.

// File: rtl/fgpio_pkg.sv
package fgpio_pkg;

   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      OFS_PINS  = 3'd0,
      OFS_LATCH = 3'd1,
      OFS_SET   = 3'd2,
      OFS_CLR   = 3'd3,
      OFS_DIR   = 3'd4,
      OFS_MASK  = 3'd5,
      OFS_RSV6  = 3'd6,
      OFS_RSV7  = 3'd7
   } fgpio_ofs_e;

   typedef struct packed {
      logic pins;
      logic set;
      logic clr;
      logic dir;
      logic mask;
   } fgpio_wsel_t;

endpackage

// File: rtl/fgpio_lane_expand.sv
module fgpio_lane_expand #(
   parameter int unsigned PORT_W = 32,
   localparam int unsigned LANES = PORT_W / 8
) (
   input  logic [LANES-1:0]  be,
   output logic [PORT_W-1:0] bits
);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign bits[8*k +: 8] = {8{be[k]}};
   end

endmodule

// File: rtl/fgpio_sync.sv
module fgpio_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/fgpio_regs.sv
module fgpio_regs
   import fgpio_pkg::*;
#(
   parameter int unsigned PORT_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  fgpio_wsel_t       wsel,
   input  logic [PORT_W-1:0] wdata,
   input  logic [PORT_W-1:0] lanes,
   output logic [PORT_W-1:0] dir_q,
   output logic [PORT_W-1:0] mask_q,
   output logic [PORT_W-1:0] latch_q
);

   logic [PORT_W-1:0] rise_v;
   logic [PORT_W-1:0] fall_v;
   logic [PORT_W-1:0] latch_d;
   logic [PORT_W-1:0] dir_d;
   logic [PORT_W-1:0] mask_d;
   logic [PORT_W-1:0] grp_en;

   // Every latch update is expressed as a rise vector and a fall vector;
   // a fall overrides a rise on the same bit.
   assign grp_en = lanes & ~mask_q;

   always_comb begin
      rise_v = '0;
      fall_v = '0;
      if (wsel.set) rise_v = wdata & lanes;
      if (wsel.clr) fall_v = wdata & lanes;
      if (wsel.pins) begin
         rise_v = wdata & grp_en;
         fall_v = ~wdata & grp_en;
      end
      latch_d = (latch_q | rise_v) & ~fall_v;
   end

   assign dir_d  = wsel.dir  ? ((dir_q  & ~lanes) | (wdata & lanes)) : dir_q;
   assign mask_d = wsel.mask ? ((mask_q & ~lanes) | (wdata & lanes)) : mask_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         dir_q   <= '0;
         mask_q  <= '0;
         latch_q <= '0;
      end else begin
         dir_q   <= dir_d;
         mask_q  <= mask_d;
         latch_q <= latch_d;
      end
   end

endmodule

// File: rtl/fgpio_rdmux.sv
module fgpio_rdmux
   import fgpio_pkg::*;
#(
   parameter int unsigned PORT_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd,
   input  fgpio_ofs_e        ofs,
   input  logic [PORT_W-1:0] pins_sync,
   input  logic [PORT_W-1:0] dir_q,
   input  logic [PORT_W-1:0] mask_q,
   input  logic [PORT_W-1:0] latch_q,
   output logic [PORT_W-1:0] rdata,
   output logic              rdata_vld
);

   logic [PORT_W-1:0] sel_d;

   always_comb begin
      unique case (ofs)
         OFS_PINS:  sel_d = pins_sync & ~mask_q;
         OFS_LATCH: sel_d = latch_q;
         OFS_DIR:   sel_d = dir_q;
         OFS_MASK:  sel_d = mask_q;
         default:   sel_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata     <= '0;
         rdata_vld <= 1'b0;
      end else begin
         rdata_vld <= rd;
         if (rd) rdata <= sel_d;
      end
   end

endmodule

// File: rtl/fgpio_port.sv
module fgpio_port
   import fgpio_pkg::*;
#(
   parameter int unsigned PORT_W      = 32,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned LANES      = PORT_W / 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                req,
   input  logic                we,
   input  logic [REG_AW-1:0]   addr,
   input  logic [LANES-1:0]    be,
   input  logic [PORT_W-1:0]   wdata,
   output logic [PORT_W-1:0]   rdata,
   output logic                rdata_vld,
   input  logic [PORT_W-1:0]   pin_in,
   output logic [PORT_W-1:0]   pin_out,
   output logic [PORT_W-1:0]   pin_oe
);

   if (PORT_W < 8 || (PORT_W % 8) != 0) begin : g_bad_width
      $error("fgpio_port: PORT_W must be a non-zero multiple of 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fgpio_port: SYNC_STAGES must be at least 2");
   end

   fgpio_ofs_e        ofs;
   fgpio_wsel_t       wsel;
   logic              wr;
   logic              rd;
   logic [PORT_W-1:0] lanes;
   logic [PORT_W-1:0] pins_sync;
   logic [PORT_W-1:0] dir_q;
   logic [PORT_W-1:0] mask_q;
   logic [PORT_W-1:0] latch_q;

   assign ofs = fgpio_ofs_e'(addr);
   assign wr  = req &  we;
   assign rd  = req & ~we;

   always_comb begin
      wsel      = '0;
      wsel.pins = wr && (ofs == OFS_PINS);
      wsel.set  = wr && (ofs == OFS_SET);
      wsel.clr  = wr && (ofs == OFS_CLR);
      wsel.dir  = wr && (ofs == OFS_DIR);
      wsel.mask = wr && (ofs == OFS_MASK);
   end

   fgpio_lane_expand #(.PORT_W(PORT_W)) u_lanes (
      .be   (be),
      .bits (lanes)
   );

   fgpio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pin_in),
      .q   (pins_sync)
   );

   fgpio_regs #(.PORT_W(PORT_W)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wsel    (wsel),
      .wdata   (wdata),
      .lanes   (lanes),
      .dir_q   (dir_q),
      .mask_q  (mask_q),
      .latch_q (latch_q)
   );

   fgpio_rdmux #(.PORT_W(PORT_W)) u_rdmux (
      .clk       (clk),
      .rst       (rst),
      .rd        (rd),
      .ofs       (ofs),
      .pins_sync (pins_sync),
      .dir_q     (dir_q),
      .mask_q    (mask_q),
      .latch_q   (latch_q),
      .rdata     (rdata),
      .rdata_vld (rdata_vld)
   );

   assign pin_out = latch_q;
   assign pin_oe  = dir_q;

endmodule

// File: rtl/fgpio_port_chk.sv
module fgpio_port_chk #(
   parameter int unsigned PORT_W = 32,
   localparam int unsigned LANES = PORT_W / 8
) (
   input logic              clk,
   input logic              rst,
   input logic              req,
   input logic              we,
   input logic [2:0]        addr,
   input logic [LANES-1:0]  be,
   input logic [PORT_W-1:0] wdata,
   input logic [PORT_W-1:0] rdata,
   input logic              rdata_vld,
   input logic [PORT_W-1:0] pin_out,
   input logic [PORT_W-1:0] pin_oe,
   input logic [PORT_W-1:0] mask_q
);

   logic [PORT_W-1:0] lane_c;
   logic [PORT_W-1:0] hit_c;
   logic              wr_c;
   logic              rd_c;

   always_comb begin
      for (int b = 0; b < PORT_W; b++) lane_c[b] = be[b/8];
   end
   assign hit_c = wdata & lane_c;
   assign wr_c  = req & we;
   assign rd_c  = req & ~we;

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> (pin_out == '0 && pin_oe == '0 && !rdata_vld));

   assert_dir_load_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_c && addr == 3'd4) |=> ((pin_oe & $past(lane_c)) == $past(hit_c)));

   assert_set_hits_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_c && addr == 3'd2) |=> ((pin_out & $past(hit_c)) == $past(hit_c)));

   assert_set_keeps_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_c && addr == 3'd2) |=> ((pin_out & ~$past(hit_c)) == ($past(pin_out) & ~$past(hit_c))));

   assert_clr_hits_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_c && addr == 3'd3) |=> ((pin_out & $past(hit_c)) == '0));

   assert_masked_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (wr_c && addr == 3'd0) |=> (((pin_out ^ $past(pin_out)) & $past(mask_q)) == '0));

   assert_pins_masked_R6: assert property (@(posedge clk) disable iff (rst)
      (rd_c && addr == 3'd0) |=> ((rdata & $past(mask_q)) == '0));

   assert_read_valid_R9: assert property (@(posedge clk) disable iff (rst)
      rd_c |=> rdata_vld);

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      !rd_c |=> !rdata_vld);

   assert_ro_write_R11: assert property (@(posedge clk) disable iff (rst)
      (wr_c && (addr == 3'd1 || addr == 3'd6 || addr == 3'd7))
         |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind fgpio_port fgpio_port_chk #(.PORT_W(PORT_W)) i_chk (
   .clk       (clk),
   .rst       (rst),
   .req       (req),
   .we        (we),
   .addr      (addr),
   .be        (be),
   .wdata     (wdata),
   .rdata     (rdata),
   .rdata_vld (rdata_vld),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .mask_q    (mask_q)
);

// File: tb/test_fgpio_port.sv
`timescale 1ns/1ps
module test_fgpio_port;

   localparam int W = 32;
   localparam int L = W / 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req = 1'b0;
   logic          we = 1'b0;
   logic [2:0]    addr = '0;
   logic [L-1:0]  be = '0;
   logic [W-1:0]  wdata = '0;
   logic [W-1:0]  rdata;
   logic          rdata_vld;
   logic [W-1:0]  pin_in = '0;
   logic [W-1:0]  pin_out;
   logic [W-1:0]  pin_oe;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   logic [W-1:0] m_dir = '0, m_mask = '0, m_lat = '0;
   logic [W-1:0] hist[$];

   always #4 clk = ~clk;

   fgpio_port i_fgpio_port (
      .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .be(be),
      .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   function automatic logic [W-1:0] lanes_of(input logic [L-1:0] e);
      logic [W-1:0] r;
      for (int b = 0; b < W; b++) r[b] = e[b/8];
      return r;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // pin history: hist[0] is the value captured at the latest edge
   always @(posedge clk) begin
      hist.push_front(rst ? '0 : pin_in);
      if (hist.size() > 8) void'(hist.pop_back());
   end

   // compare outputs against the model every cycle (R10: pin_out is latch, pin_oe is dir)
   always @(negedge clk) begin
      if (!done) begin
         check("R10 pin_out", pin_out, m_lat);
         check("R2 pin_oe", pin_oe, m_dir);
      end
   end

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input logic [L-1:0] e);
      logic [W-1:0] ln;
      @(negedge clk);
      req = 1; we = 1; addr = a; wdata = d; be = e;
      @(posedge clk); #1;
      ln = lanes_of(e);
      case (a)
         3'd0: m_lat = (m_lat & ~(ln & ~m_mask)) | (d & ln & ~m_mask);
         3'd2: m_lat = m_lat | (d & ln);
         3'd3: m_lat = m_lat & ~(d & ln);
         3'd4: m_dir = (m_dir & ~ln) | (d & ln);
         3'd5: m_mask = (m_mask & ~ln) | (d & ln);
         default: ;
      endcase
      @(negedge clk);
      req = 0; we = 0;
   endtask

   task automatic rd(input logic [2:0] a, input string tag);
      logic [W-1:0] exp;
      @(negedge clk);
      req = 1; we = 0; addr = a;
      @(posedge clk); #1;
      case (a)
         3'd0: exp = hist[2] & ~m_mask;
         3'd1: exp = m_lat;
         3'd4: exp = m_dir;
         3'd5: exp = m_mask;
         default: exp = '0;
      endcase
      @(negedge clk);
      req = 0;
      check({tag, " R9 vld"}, {31'b0, rdata_vld}, 32'd1);
      check(tag, rdata, exp);
      @(negedge clk);
      check("R9 vld low", {31'b0, rdata_vld}, 32'd0);
   endtask

   initial begin
      #(8 * 150000);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 pin_out", pin_out, '0);
      check("R1 pin_oe", pin_oe, '0);
      check("R1 vld", {31'b0, rdata_vld}, '0);
      rst = 0;
      rd(3'd4, "R1 dir");
      rd(3'd5, "R1 mask");

      wr(3'd4, 32'h00FF_00FF, 4'hF);
      rd(3'd4, "R2 dir");
      wr(3'd4, 32'hFFFF_FFFF, 4'b0100);
      rd(3'd4, "R7 dir lane");
      check("R7 dir lane value", pin_oe, 32'h00FF_00FF | 32'h00FF_0000);

      wr(3'd2, 32'h0000_F00F, 4'hF);
      check("R3 set", pin_out, 32'h0000_F00F);
      wr(3'd2, 32'hFFFF_FFFF, 4'b0001);
      check("R7 set lane", pin_out, 32'h0000_F0FF);
      wr(3'd3, 32'h0000_000F, 4'hF);
      check("R4 clr", pin_out, 32'h0000_F0F0);
      wr(3'd3, 32'hFFFF_FFFF, 4'b0010);
      check("R7 clr lane", pin_out, 32'h0000_00F0);

      wr(3'd5, 32'hFFFF_0000, 4'hF);
      rd(3'd5, "R5 mask rb");
      wr(3'd0, 32'hAAAA_AAAA, 4'hF);
      check("R5 masked write", pin_out, 32'h0000_AAAA);
      wr(3'd0, 32'h5555_5555, 4'b0010);
      check("R7 value lane", pin_out, 32'h0000_55AA);
      rd(3'd1, "R10 latch rb");

      pin_in = 32'h1234_5678;
      rd(3'd0, "R8 early read");
      rd(3'd0, "R6 masked pins");
      check("R6 masked pins value", rdata, 32'h0000_5678);
      wr(3'd5, 32'h0000_0000, 4'hF);
      pin_in = 32'hCAFE_F00D;
      rd(3'd0, "R8 latency");
      rd(3'd0, "R8 settled");
      check("R8 settled value", rdata, 32'hCAFE_F00D);

      wr(3'd1, 32'hFFFF_FFFF, 4'hF);
      wr(3'd6, 32'hFFFF_FFFF, 4'hF);
      wr(3'd7, 32'hFFFF_FFFF, 4'hF);
      check("R11 latch unchanged", pin_out, 32'h0000_55AA);
      rd(3'd4, "R11 dir unchanged");
      rd(3'd5, "R11 mask unchanged");
      rd(3'd2, "R10 set reads zero");
      rd(3'd6, "R10 rsv reads zero");

      pin_in = '0;
      repeat (4) @(negedge clk);
      rst = 1;
      @(posedge clk); #1;
      m_dir = '0; m_mask = '0; m_lat = '0;
      @(negedge clk);
      check("R1 reset latch", pin_out, '0);
      check("R1 reset dir", pin_oe, '0);
      rst = 0;
      rd(3'd5, "R1 reset mask");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule